// File: doc/BRIEF.md
# Fuse Burn Sequencer

This block drives a one-time-programmable fuse macro through one full burn. A single start pulse makes it pick the macro timing from the bus clock frequency band. It then unlocks programming with a 16-bit key and issues a program command. When the command register reads zero again, it switches to the read key and issues a read command, so that the fused values are copied back. A one-cycle done pulse marks the end of the read phase.

The configuration key register and the command register are visible at the ports. While the sequencer is idle and no command is pending, a host can also write them directly. A command starts the macro only if the matching key is present. A command without its key is dropped and raises an error flag. The macro is told how long each operation lasts, which is the sum of the two timing selectors. It answers with a done strobe, and the command register clears on the following cycle.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset conf_o and cmd_o are zero, the timing outputs are zero, and busy_o, done_o, err_o and macro_start_o are low.
- R2: With bus_mhz_i at or below 26 the applied timing is sel0_o=250, sel1_o=255, dac_div_o=52.
- R3: With bus_mhz_i from 27 to 40 the applied timing is sel0_o=160, sel1_o=255, dac_div_o=80.
- R4: With bus_mhz_i above 40 the applied timing is sel0_o=80, sel1_o=128, dac_div_o=100; in every band macro_len_o equals sel0_o+sel1_o.
- R5: A burn issues exactly two macro starts. The first is a program (cmd_o=2, macro_prog_o=1) with conf_o=0x5A5A. The second is a read (cmd_o=1, macro_prog_o=0) with conf_o=0x5AA5, issued only after cmd_o has returned to zero.
- R6: A command code (wdata bits [1:0], 2=program, 1=read) is accepted only when conf_o holds the matching key. Program needs 0x5A5A and read needs 0x5AA5. Otherwise cmd_o stays zero, no macro start occurs and err_o is set on the next cycle. An accepted command clears err_o.
- R7: An accepted command stays in cmd_o from the cycle after the write until the cycle after macro_done_i is high, and then reads zero.
- R8: done_o is a one-cycle pulse in which busy_o is low, cmd_o is zero and conf_o is 0x5AA5.
- R9: start_i while busy_o is high is ignored, so one start gives exactly one done pulse.
- R10: Host writes (host_wr_i) while busy_o is high or cmd_o is nonzero have no effect.
- R11: prog_force_o is high while conf_o holds 0x5A5A and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a full burn |
| bus_mhz_i | input | 8 | Bus clock frequency in MHz |
| host_wr_i | input | 1 | Host register write strobe |
| host_sel_cmd_i | input | 1 | 0 selects the key register, 1 the command register |
| host_wdata_i | input | 16 | Host write data |
| macro_done_i | input | 1 | Fuse macro finished the current operation |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle end-of-burn pulse |
| err_o | output | 1 | Last command was rejected for a missing key |
| conf_o | output | 16 | Configuration key register |
| cmd_o | output | 2 | Command register, zero when idle |
| sel0_o | output | 8 | Timing selector 0 |
| sel1_o | output | 8 | Timing selector 1 |
| dac_div_o | output | 8 | DAC clock divider |
| prog_force_o | output | 1 | Programming enabled, read/write-disable forced off |
| macro_start_o | output | 1 | Start strobe to the fuse macro |
| macro_prog_o | output | 1 | 1 for program, 0 for read |
| macro_len_o | output | 9 | Operation length in cycles |

## Verification
Full burns are run at 26, 27, 40 and 41 MHz. These values sit on both sides of each band edge, so an off-by-one compare picks the wrong timing triple. The same runs also show a wrong macro length as a wrong length of the command window. Host command writes with a foreign key, with the read key for a program and with the correct key tell key gating apart from plain code decoding. The last case also shows that the error flag clears. A burn that receives a second start and a host key write in mid-run separates ignored requests from a restart or a corrupted key.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int KEY_W  = 16;
  localparam int CMD_W  = 2;
  localparam int TIM_W  = 8;
  localparam logic [KEY_W-1:0] KEY_PGM = 16'h5A5A;
  localparam logic [KEY_W-1:0] KEY_RD  = 16'h5AA5;
  localparam logic [CMD_W-1:0] CMD_NONE = 2'd0;
  localparam logic [CMD_W-1:0] CMD_RD   = 2'd1;
  localparam logic [CMD_W-1:0] CMD_PGM  = 2'd2;

  typedef struct packed {
    logic [TIM_W-1:0] sel0;
    logic [TIM_W-1:0] sel1;
    logic [TIM_W-1:0] dac_div;
  } fuse_tim_t;

  typedef enum logic [2:0] {
    S_IDLE, S_TIM, S_PKEY, S_PCMD, S_PWAIT, S_RKEY, S_RCMD, S_RWAIT
  } seq_st_e;
endpackage

// File: rtl/fuse_timing_sel.sv
module fuse_timing_sel
  import fuse_pkg::*;
#(
  parameter int MHZ_W   = 8,
  parameter int LOW_MHZ = 26,
  parameter int MID_MHZ = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MHZ_W-1:0] mhz_i,
  output fuse_tim_t        tim_o
);
  fuse_tim_t band_d, tim_q;

  always_comb begin
    if (int'(mhz_i) <= LOW_MHZ)      band_d = '{sel0: 8'd250, sel1: 8'd255, dac_div: 8'd52};
    else if (int'(mhz_i) <= MID_MHZ) band_d = '{sel0: 8'd160, sel1: 8'd255, dac_div: 8'd80};
    else                             band_d = '{sel0: 8'd80,  sel1: 8'd128, dac_div: 8'd100};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tim_q <= '0;
    else if (load_i) tim_q <= band_d;
  end

  assign tim_o = tim_q;
endmodule

// File: rtl/fuse_cmd_unit.sv
module fuse_cmd_unit
  import fuse_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_conf_i,
  input  logic             wr_cmd_i,
  input  logic [KEY_W-1:0] wdata_i,
  input  logic             macro_done_i,
  output logic [KEY_W-1:0] conf_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             err_o,
  output logic             macro_start_o
);
  logic [KEY_W-1:0] conf_q;
  logic [CMD_W-1:0] cmd_q, code;
  logic             err_q, start_q, is_cmd, key_ok;

  always_comb begin
    code   = wdata_i[CMD_W-1:0];
    is_cmd = (code == CMD_PGM) || (code == CMD_RD);
    key_ok = ((code == CMD_PGM) && (conf_q == KEY_PGM)) ||
             ((code == CMD_RD)  && (conf_q == KEY_RD));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conf_q  <= '0;
      cmd_q   <= CMD_NONE;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr_conf_i) conf_q <= wdata_i;
      if (wr_cmd_i && is_cmd) begin
        if (key_ok) begin
          cmd_q   <= code;
          err_q   <= 1'b0;
          start_q <= 1'b1;
        end else begin
          err_q   <= 1'b1;   // rejected: register never shows the code
        end
      end else if (macro_done_i && (cmd_q != CMD_NONE)) begin
        cmd_q <= CMD_NONE;
      end
    end
  end

  assign conf_o        = conf_q;
  assign cmd_o         = cmd_q;
  assign err_o         = err_q;
  assign macro_start_o = start_q;
endmodule

// File: rtl/fuse_seq_fsm.sv
module fuse_seq_fsm
  import fuse_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmd_idle_i,
  output logic             load_tim_o,
  output logic             wr_conf_o,
  output logic             wr_cmd_o,
  output logic [KEY_W-1:0] wdata_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_st_e st_q, st_d;
  logic    done_q;

  always_comb begin
    st_d       = st_q;
    load_tim_o = 1'b0;
    wr_conf_o  = 1'b0;
    wr_cmd_o   = 1'b0;
    wdata_o    = '0;
    unique case (st_q)
      S_IDLE:  if (start_i && cmd_idle_i) st_d = S_TIM;
      S_TIM:   begin load_tim_o = 1'b1; st_d = S_PKEY; end
      S_PKEY:  begin wr_conf_o = 1'b1; wdata_o = KEY_PGM; st_d = S_PCMD; end
      S_PCMD:  begin wr_cmd_o = 1'b1; wdata_o = {{(KEY_W-CMD_W){1'b0}}, CMD_PGM}; st_d = S_PWAIT; end
      S_PWAIT: if (cmd_idle_i) st_d = S_RKEY;
      S_RKEY:  begin wr_conf_o = 1'b1; wdata_o = KEY_RD; st_d = S_RCMD; end
      S_RCMD:  begin wr_cmd_o = 1'b1; wdata_o = {{(KEY_W-CMD_W){1'b0}}, CMD_RD}; st_d = S_RWAIT; end
      S_RWAIT: if (cmd_idle_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == S_RWAIT) && cmd_idle_i;
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
  import fuse_pkg::*;
#(
  parameter int MHZ_W   = 8,
  parameter int LOW_MHZ = 26,
  parameter int MID_MHZ = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MHZ_W-1:0] bus_mhz_i,
  input  logic             host_wr_i,
  input  logic             host_sel_cmd_i,
  input  logic [15:0]      host_wdata_i,
  input  logic             macro_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [15:0]      conf_o,
  output logic [1:0]       cmd_o,
  output logic [7:0]       sel0_o,
  output logic [7:0]       sel1_o,
  output logic [7:0]       dac_div_o,
  output logic             prog_force_o,
  output logic             macro_start_o,
  output logic             macro_prog_o,
  output logic [8:0]       macro_len_o
);
  fuse_tim_t        tim;
  logic             load_tim, seq_wr_conf, seq_wr_cmd, seq_busy, cmd_idle, host_ok;
  logic [KEY_W-1:0] seq_wdata, wdata;
  logic             wr_conf, wr_cmd;

  assign cmd_idle = (cmd_o == CMD_NONE);
  assign host_ok  = host_wr_i && !seq_busy && cmd_idle;
  assign wr_conf  = seq_wr_conf || (host_ok && !host_sel_cmd_i);
  assign wr_cmd   = seq_wr_cmd  || (host_ok &&  host_sel_cmd_i);
  assign wdata    = seq_busy ? seq_wdata : host_wdata_i;

  fuse_seq_fsm u_fsm (
    .clk_i, .rst_ni, .start_i,
    .cmd_idle_i (cmd_idle),
    .load_tim_o (load_tim),
    .wr_conf_o  (seq_wr_conf),
    .wr_cmd_o   (seq_wr_cmd),
    .wdata_o    (seq_wdata),
    .busy_o     (seq_busy),
    .done_o     (done_o)
  );

  fuse_timing_sel #(.MHZ_W(MHZ_W), .LOW_MHZ(LOW_MHZ), .MID_MHZ(MID_MHZ)) u_tim (
    .clk_i, .rst_ni,
    .load_i (load_tim),
    .mhz_i  (bus_mhz_i),
    .tim_o  (tim)
  );

  fuse_cmd_unit u_cmd (
    .clk_i, .rst_ni,
    .wr_conf_i     (wr_conf),
    .wr_cmd_i      (wr_cmd),
    .wdata_i       (wdata),
    .macro_done_i,
    .conf_o,
    .cmd_o,
    .err_o,
    .macro_start_o
  );

  assign busy_o       = seq_busy;
  assign sel0_o       = tim.sel0;
  assign sel1_o       = tim.sel1;
  assign dac_div_o    = tim.dac_div;
  assign macro_len_o  = {1'b0, tim.sel0} + {1'b0, tim.sel1};
  assign prog_force_o = (conf_o == KEY_PGM);
  assign macro_prog_o = (cmd_o == CMD_PGM);
endmodule

// File: rtl/fuse_burn_seq_chk.sv
module fuse_burn_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        host_wr_i,
  input logic        host_sel_cmd_i,
  input logic [15:0] host_wdata_i,
  input logic        macro_done_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] conf_o,
  input logic [1:0]  cmd_o,
  input logic        macro_start_o,
  input logic        macro_prog_o
);
  a_r5_pgm_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    macro_start_o && macro_prog_o |-> conf_o == 16'h5A5A);

  a_r5_rd_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    macro_start_o && !macro_prog_o |-> conf_o == 16'h5AA5 && cmd_o == 2'd1);

  a_r6_reject_pgm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_sel_cmd_i && !busy_o && cmd_o == 2'd0 &&
    host_wdata_i[1:0] == 2'd2 && conf_o != 16'h5A5A
    |=> cmd_o == 2'd0 && err_o && !macro_start_o);

  a_r7_clear_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    macro_done_i && cmd_o != 2'd0 |=> cmd_o == 2'd0);

  a_r7_hold_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o != 2'd0 && !macro_done_i |=> $stable(cmd_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && cmd_o == 2'd0 && conf_o == 16'h5AA5);

  a_r9_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && cmd_o == 2'd0 |=> busy_o);
endmodule

bind fuse_burn_seq fuse_burn_seq_chk u_chk (
  .clk_i, .rst_ni, .start_i, .host_wr_i, .host_sel_cmd_i, .host_wdata_i,
  .macro_done_i, .busy_o, .done_o, .err_o, .conf_o, .cmd_o,
  .macro_start_o, .macro_prog_o
);

// File: tb/fuse_burn_seq_test.sv
module fuse_burn_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  bus_mhz = 8'd26;
  logic        host_wr = 1'b0;
  logic        host_sel_cmd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        macro_done;
  logic        busy, done, err, prog_force, macro_start, macro_prog;
  logic [15:0] conf;
  logic [1:0]  cmd;
  logic [7:0]  sel0, sel1, dac_div;
  logic [8:0]  macro_len;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  fuse_burn_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bus_mhz_i(bus_mhz),
    .host_wr_i(host_wr), .host_sel_cmd_i(host_sel_cmd), .host_wdata_i(host_wdata),
    .macro_done_i(macro_done), .busy_o(busy), .done_o(done), .err_o(err),
    .conf_o(conf), .cmd_o(cmd), .sel0_o(sel0), .sel1_o(sel1), .dac_div_o(dac_div),
    .prog_force_o(prog_force), .macro_start_o(macro_start),
    .macro_prog_o(macro_prog), .macro_len_o(macro_len)
  );

  // fuse macro model: done strobe after macro_len cycles
  logic [9:0] mcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mcnt <= '0;
    else if (macro_start) mcnt <= {1'b0, macro_len};
    else if (mcnt != 0)   mcnt <= mcnt - 1'b1;
  end
  assign macro_done = (mcnt == 10'd1);

  // monitor
  int n_start, n_done, n_run, run_cur;
  int st_prog [2];
  int st_conf [2];
  int st_force[2];
  int runs    [2];
  always @(negedge clk) begin
    if (rst_n) begin
      if (macro_start) begin
        if (n_start < 2) begin
          st_prog[n_start]  = int'(macro_prog);
          st_conf[n_start]  = int'(conf);
          st_force[n_start] = int'(prog_force);
        end
        n_start++;
      end
      if (cmd != 2'd0) run_cur++;
      else if (run_cur != 0) begin
        if (n_run < 2) runs[n_run] = run_cur;
        n_run++;
        run_cur = 0;
      end
      if (done) n_done++;
    end
  end

  task automatic clear_mon();
    @(posedge clk);
    n_start = 0; n_done = 0; n_run = 0; run_cur = 0;
    for (int i = 0; i < 2; i++) begin
      st_prog[i] = -1; st_conf[i] = -1; st_force[i] = -1; runs[i] = -1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input bit sel_cmd, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel_cmd = sel_cmd; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    #1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && n_done == 0; i++) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic test_reset();
    #1;
    chk("R1 conf", int'(conf), 0);
    chk("R1 cmd", int'(cmd), 0);
    chk("R1 flags", int'({busy, done, err, macro_start}), 0);
    chk("R1 timing", int'({sel0, sel1, dac_div}), 0);
  endtask

  task automatic test_burn(input int mhz, input int e0, input int e1, input int ed, input string req);
    @(negedge clk); bus_mhz = 8'(mhz);
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk({req, " sel0"}, int'(sel0), e0);
    chk({req, " sel1"}, int'(sel1), e1);
    chk({req, " dac_div"}, int'(dac_div), ed);
    chk("R4 macro_len", int'(macro_len), e0 + e1);
    chk("R5 start count", n_start, 2);
    chk("R5 first is program", st_prog[0], 1);
    chk("R5 program key", st_conf[0], 16'h5A5A);
    chk("R11 force during program", st_force[0], 1);
    chk("R5 second is read", st_prog[1], 0);
    chk("R5 read key", st_conf[1], 16'h5AA5);
    chk("R7 program window", runs[0], e0 + e1 + 1);
    chk("R7 read window", runs[1], e0 + e1 + 1);
    chk("R8 done count", n_done, 1);
    chk("R8 busy low", int'(busy), 0);
    chk("R8 conf after burn", int'(conf), 16'h5AA5);
    chk("R11 force released", int'(prog_force), 0);
  endtask

  task automatic test_reject();
    clear_mon();
    host_write(1'b0, 16'h1234);
    chk("R6 foreign key stored", int'(conf), 16'h1234);
    host_write(1'b1, 16'h0002);
    chk("R6 pgm rejected cmd", int'(cmd), 0);
    chk("R6 pgm rejected err", int'(err), 1);
    host_write(1'b0, 16'h5AA5);
    host_write(1'b1, 16'h0002);
    chk("R6 pgm with read key cmd", int'(cmd), 0);
    chk("R6 pgm with read key err", int'(err), 1);
    chk("R6 no macro start", n_start, 0);
    host_write(1'b1, 16'h0001);
    chk("R6 read accepted cmd", int'(cmd), 1);
    chk("R6 err cleared", int'(err), 0);
    host_write(1'b0, 16'h0000);
    chk("R10 conf write while cmd pending", int'(conf), 16'h5AA5);
    for (int i = 0; i < 4000 && cmd != 2'd0; i++) @(negedge clk);
    #1;
    chk("R7 read cmd cleared", int'(cmd), 0);
    chk("R6 one macro start", n_start, 1);
  endtask

  task automatic test_busy_ignore();
    @(negedge clk); bus_mhz = 8'd50;
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 100 && n_start == 0; i++) @(posedge clk);
    @(negedge clk);
    host_wr = 1'b1; host_sel_cmd = 1'b0; host_wdata = 16'h0000; start = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; start = 1'b0;
    #1;
    chk("R10 conf kept during burn", int'(conf), 16'h5A5A);
    chk("R9 still busy", int'(busy), 1);
    wait_done();
    repeat (20) @(negedge clk);
    #1;
    chk("R9 single done", n_done, 1);
    chk("R9 no restart", int'(busy), 0);
    chk("R9 two starts only", n_start, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    @(negedge clk); rst_n = 1'b1;
    test_burn(26, 250, 255, 52,  "R2");
    test_burn(27, 160, 255, 80,  "R3");
    test_burn(40, 160, 255, 80,  "R3");
    test_burn(41, 80,  128, 100, "R4");
    test_reject();
    test_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule